// File: doc/BRIEF.md
# Keyed Watchdog Timer with Selective Reset Output

The block is a watchdog on a simple 32-bit register bus. A 32-bit down-counter is loaded from a reload register only when software writes a fixed key word to the kick register. While the counter is enabled it loses one count per timebase tick. The timebase is either a 1 MHz tick made from the system clock by a prescaler, or the system clock itself. When the count runs out, a sticky timeout flag is set. If resets are enabled, the block raises a reset request for a programmable number of ticks. For that time it also shows a 2-bit reset scope and a 64-bit per-peripheral reset mask, captured at the moment of expiry. It then clears its own enable bit.

Software arms the block by writing the reload value, writing the key, and then setting the enable bit. It services the watchdog by writing the key again before the count runs out. The block only produces the request, the scope and the mask. Downstream reset logic is not part of it.

Top module: `wdg_top`

## Requirements
- R1: After reset, control, counter, timeout flag and both mask words read 0, the pulse-width register reads 0x00FF, and the reset request, scope and mask outputs are 0.
- R2: Word address map: 0 live counter (read only), 1 reload, 2 kick (reads 0), 3 control, 4 timeout flag in bit 0 (read only), 5 timeout clear (write only), 6 pulse width (16 bits), 7 mask low word, 8 mask high word. Unmapped addresses read 0 and ignore writes. Control keeps only bit 0 enable, bit 1 reset-on-expiry, bit 4 prescaled-timebase select, bits 6:5 scope and bit 7 alternate-boot flag; its other bits read 0.
- R3: Writing 0x00004755 to the kick register loads the counter from the reload register, whether or not the counter is enabled.
- R4: Writing any other value to the kick register leaves the counter unchanged.
- R5: While enable is 1 the counter drops by one per tick. While enable is 0 it holds its value.
- R6: With control bit 4 at 1, a tick occurs once every TICK_DIV system clocks (50 by default). With bit 4 at 0, every system clock is a tick.
- R7: An enabled counter holding N >= 1 expires on its N-th tick (a reload of 0 expires on the first tick) and then holds 0. The timeout flag rises on the same clock edge and stays set.
- R8: Any write to the timeout-clear register clears the timeout flag, unless an expiry occurs in the same cycle.
- R9: On expiry with reset-on-expiry set, the reset request is high from that clock edge for exactly W ticks, where W is the pulse-width register (W = 0 acts as 1).
- R10: While the request is high, the scope output carries control bits 6:5 (0 SoC, 1 full chip, 2 processor only) and the mask output carries {mask high word, mask low word}, both as they stood at expiry. Both outputs are 0 when the request is low.
- R11: An expiry with reset-on-expiry set clears the enable bit in hardware.
- R12: An expiry with reset-on-expiry clear sets the timeout flag but raises no request and leaves enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, with bus_sel_i |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| wdt_rst_o | output | 1 | Reset request pulse |
| wdt_rst_mode_o | output | 2 | Reset scope during the pulse |
| wdt_rst_mask_o | output | 64 | Per-peripheral reset mask during the pulse |

## Verification
The bench goes after the kick key: a near-miss value must not reload the counter, so a design that compares too few key bits would show a changed count. It times the expiry edge and the pulse length to the exact cycle, which exposes off-by-one errors in the expiry test (firing at 1 instead of 0, or one tick late) and in the width counter (a pulse one cycle long or short). It writes the mask while the counter is stopped and expects the new value on the next expiry. It also checks that a non-reset expiry leaves enable set, and that a width of 0 still gives a one-tick pulse. Over a fixed window, the prescaled timebase must give exactly one count per TICK_DIV clocks.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CNT     = 4'd0;
  localparam logic [ADDR_W-1:0] OFF_RELOAD  = 4'd1;
  localparam logic [ADDR_W-1:0] OFF_KICK    = 4'd2;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 4'd3;
  localparam logic [ADDR_W-1:0] OFF_TMO     = 4'd4;
  localparam logic [ADDR_W-1:0] OFF_TMO_CLR = 4'd5;
  localparam logic [ADDR_W-1:0] OFF_WIDTH   = 4'd6;
  localparam logic [ADDR_W-1:0] OFF_MASK0   = 4'd7;

  localparam logic [31:0] KICK_KEY = 32'h0000_4755;

  typedef enum logic [1:0] {
    MODE_SOC  = 2'd0,
    MODE_FULL = 2'd1,
    MODE_CORE = 2'd2,
    MODE_RSVD = 2'd3
  } rst_mode_e;

  typedef struct packed {
    logic      alt_boot;
    rst_mode_e mode;
    logic      slow_tb;
    logic      rst_en;
    logic      en;
  } ctrl_t;
endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int unsigned TICK_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  logic pre_tick;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign pre_tick = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end

      assign pre_tick = (div_q == LAST);
    end
  endgenerate

  assign tick_o = slow_i ? pre_tick : 1'b1;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last     = (cnt_q <= CNT_W'(1));
  assign expire_o = en_i & tick_i & ~load_i & last;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= reload_i;
    else if (en_i && tick_i)  cnt_q <= last ? '0 : cnt_q - 1'b1;
  end

  // R5
  a_r5_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_q));
  // R5
  a_r5_never_counts_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int unsigned WIDTH_W = 16,
  parameter int unsigned MASK_W  = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               expire_i,
  input  logic               rst_en_i,
  input  logic [WIDTH_W-1:0] width_i,
  input  logic [1:0]         mode_i,
  input  logic [MASK_W-1:0]  mask_i,
  output logic               rst_o,
  output logic [1:0]         mode_o,
  output logic [MASK_W-1:0]  mask_o
);
  logic               fire;
  logic               active_q;
  logic [WIDTH_W-1:0] left_q;
  logic [1:0]         mode_q;
  logic [MASK_W-1:0]  mask_q;

  assign fire = expire_i & rst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      left_q   <= '0;
      mode_q   <= '0;
      mask_q   <= '0;
    end else if (fire) begin
      active_q <= 1'b1;
      left_q   <= (width_i == '0) ? WIDTH_W'(1) : width_i;
      mode_q   <= mode_i;
      mask_q   <= mask_i;
    end else if (active_q && tick_i) begin
      if (left_q == WIDTH_W'(1)) active_q <= 1'b0;
      else                       left_q   <= left_q - 1'b1;
    end
  end

  assign rst_o  = active_q;
  assign mode_o = active_q ? mode_q : 2'b00;
  assign mask_o = active_q ? mask_q : '0;

  // R9
  a_r9_rise_needs_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(expire_i && rst_en_i));
  // R9
  a_r9_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && !tick_i && !fire) |=> rst_o);
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned WIDTH_W   = 16,
  parameter int unsigned WIDTH_RST = 255,
  parameter int unsigned MASK_W    = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               expire_i,
  output logic               kick_o,
  output logic [CNT_W-1:0]   reload_o,
  output logic               en_o,
  output logic               rst_en_o,
  output logic               slow_o,
  output logic [1:0]         mode_o,
  output logic [WIDTH_W-1:0] width_o,
  output logic [MASK_W-1:0]  mask_o
);
  localparam int unsigned MASK_WORDS = MASK_W / 32;

  logic               wr;
  ctrl_t              ctrl_q;
  logic               tmo_q;
  logic [CNT_W-1:0]   reload_q;
  logic [WIDTH_W-1:0] width_q;
  logic [MASK_WORDS-1:0] mask_hit;

  assign wr = sel_i & we_i;

  generate
    for (genvar i = 0; i < MASK_WORDS; i++) begin : g_mask
      logic [31:0] word_q;
      assign mask_hit[i] = (addr_i == OFF_MASK0 + ADDR_W'(i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               word_q <= '0;
        else if (wr && mask_hit[i]) word_q <= wdata_i;
      end
      assign mask_o[i*32 +: 32] = word_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr && addr_i == OFF_CTRL) begin
        ctrl_q.en       <= wdata_i[0];
        ctrl_q.rst_en   <= wdata_i[1];
        ctrl_q.slow_tb  <= wdata_i[4];
        ctrl_q.mode     <= rst_mode_e'(wdata_i[6:5]);
        ctrl_q.alt_boot <= wdata_i[7];
      end
      // hardware stop wins over a same-cycle bus write
      if (expire_i && ctrl_q.rst_en) ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              tmo_q <= 1'b0;
    else if (expire_i)                        tmo_q <= 1'b1;
    else if (wr && addr_i == OFF_TMO_CLR)     tmo_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      width_q  <= WIDTH_W'(WIDTH_RST);
    end else if (wr) begin
      if (addr_i == OFF_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
      if (addr_i == OFF_WIDTH)  width_q  <= wdata_i[WIDTH_W-1:0];
    end
  end

  assign kick_o   = wr && (addr_i == OFF_KICK) && (wdata_i == KICK_KEY);
  assign reload_o = reload_q;
  assign en_o     = ctrl_q.en;
  assign rst_en_o = ctrl_q.rst_en;
  assign slow_o   = ctrl_q.slow_tb;
  assign mode_o   = ctrl_q.mode;
  assign width_o  = width_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CNT:    rdata_o = 32'(cnt_i);
      OFF_RELOAD: rdata_o = 32'(reload_q);
      OFF_CTRL:   rdata_o = {24'd0, ctrl_q.alt_boot, ctrl_q.mode, ctrl_q.slow_tb,
                             2'b00, ctrl_q.rst_en, ctrl_q.en};
      OFF_TMO:    rdata_o = {31'd0, tmo_q};
      OFF_WIDTH:  rdata_o = 32'(width_q);
      default:    rdata_o = '0;
    endcase
    for (int i = 0; i < MASK_WORDS; i++) begin
      if (mask_hit[i]) rdata_o = mask_o[i*32 +: 32];
    end
  end

  // R7
  a_r7_flag_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> tmo_q);
  // R11
  a_r11_hw_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && ctrl_q.rst_en) |=> !ctrl_q.en);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 50,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned WIDTH_W   = 16,
  parameter int unsigned WIDTH_RST = 255,
  parameter int unsigned MASK_W    = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              wdt_rst_o,
  output logic [1:0]        wdt_rst_mode_o,
  output logic [63:0]       wdt_rst_mask_o
);
  logic               tick, kick, expire;
  logic               en, rst_en, slow;
  logic [1:0]         mode;
  logic [CNT_W-1:0]   cnt, reload;
  logic [WIDTH_W-1:0] width;
  logic [MASK_W-1:0]  mask, mask_out;

  wdg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .slow_i(slow), .tick_o(tick)
  );

  wdg_regs #(
    .CNT_W(CNT_W), .WIDTH_W(WIDTH_W), .WIDTH_RST(WIDTH_RST), .MASK_W(MASK_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .cnt_i(cnt), .expire_i(expire), .kick_o(kick), .reload_o(reload),
    .en_o(en), .rst_en_o(rst_en), .slow_o(slow), .mode_o(mode),
    .width_o(width), .mask_o(mask)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .tick_i(tick),
    .load_i(kick), .reload_i(reload), .cnt_o(cnt), .expire_o(expire)
  );

  wdg_pulse #(.WIDTH_W(WIDTH_W), .MASK_W(MASK_W)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .expire_i(expire),
    .rst_en_i(rst_en), .width_i(width), .mode_i(mode), .mask_i(mask),
    .rst_o(wdt_rst_o), .mode_o(wdt_rst_mode_o), .mask_o(mask_out)
  );

  assign wdt_rst_mask_o = 64'(mask_out);

  // R12
  a_r12_no_pulse_without_rst_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(rst_en));
endmodule

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wrst;
  logic [1:0]  wmode;
  logic [63:0] wmask;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  wdg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .wdt_rst_o(wrst), .wdt_rst_mode_o(wmode), .wdt_rst_mask_o(wmask)
  );

  // {addr, write data, expected readback}
  localparam logic [67:0] VEC [10] = '{
    {4'd1,  32'h1234_5678, 32'h1234_5678},  // R2 reload
    {4'd6,  32'hFFFF_FFFF, 32'h0000_FFFF},  // R2 width 16 bits
    {4'd7,  32'hA5A5_A5A5, 32'hA5A5_A5A5},  // R2 mask low
    {4'd8,  32'h0F0F_0F0F, 32'h0F0F_0F0F},  // R2 mask high
    {4'd3,  32'hFFFF_FFFC, 32'h0000_00F0},  // R2 control bits kept
    {4'd3,  32'h0000_0002, 32'h0000_0002},  // R2 reset-on-expiry only
    {4'd4,  32'h0000_0001, 32'h0000_0000},  // R2 flag read only
    {4'd0,  32'h0000_DEAD, 32'h0000_0000},  // R2 counter read only
    {4'd2,  32'h0000_4755, 32'h0000_0000},  // R2 kick reads 0
    {4'd15, 32'hFFFF_FFFF, 32'h0000_0000}   // R2 unmapped
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    sel = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic        hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd3, d); chk("R1 ctrl", 64'(d), 64'h0);
    rd(4'd6, d); chk("R1 width", 64'(d), 64'hFF);
    rd(4'd0, d); chk("R1 counter", 64'(d), 64'h0);
    rd(4'd4, d); chk("R1 flag", 64'(d), 64'h0);
    rd(4'd7, d); chk("R1 mask low", 64'(d), 64'h0);
    chk("R1 outputs", {61'(wmask[60:0] | 61'(wmask[63:61])), wmode, wrst}, 64'h0);

    // R2 register table
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][67:64], d);
      chk($sformatf("R2 vec %0d", i), 64'(d), 64'(VEC[i][31:0]));
    end

    // R3 key reload while stopped
    wr(4'd3, 32'h0);
    wr(4'd1, 32'd100);
    wr(4'd2, 32'h4755);
    rd(4'd0, d); chk("R3 key loads", 64'(d), 64'd100);

    // R4 near-miss keys ignored
    wr(4'd1, 32'd50);
    wr(4'd2, 32'h4756);
    rd(4'd0, d); chk("R4 key+1", 64'(d), 64'd100);
    wr(4'd2, 32'h1_4755);
    rd(4'd0, d); chk("R4 high bit", 64'(d), 64'd100);

    // R5 count and stop, fast timebase
    wr(4'd3, 32'h1);
    rd(4'd0, d); chk("R5 start", 64'(d), 64'd100);
    cycles(10);
    rd(4'd0, d); chk("R5 ten ticks", 64'(d), 64'd90);
    wr(4'd3, 32'h0);
    cycles(5);
    rd(4'd0, d); chk("R5 held", 64'(d), 64'd89);

    // R6 prescaled timebase
    wr(4'd1, 32'd1000);
    wr(4'd2, 32'h4755);
    wr(4'd3, 32'h11);
    cycles(10);
    rd(4'd0, d);
    chk("R6 slow early", 64'(d == 32'd1000 || d == 32'd999), 64'd1);
    cycles(490);
    rd(4'd0, d); chk("R6 slow window", 64'(d), 64'd990);
    wr(4'd3, 32'h0);

    // R7 R9 R10 R11 expiry with reset, width 3, scope 2
    wr(4'd1, 32'd5);
    wr(4'd6, 32'd3);
    wr(4'd7, 32'h1111_1111);
    wr(4'd8, 32'h8000_0001);
    wr(4'd2, 32'h4755);
    wr(4'd3, 32'h43);
    rd(4'd4, d);
    for (int j = 1; j <= 9; j++) begin
      @(negedge clk);
      rd(4'd4, d);
      hi = (j >= 5 && j <= 7);
      chk($sformatf("R9 pulse j=%0d", j), 64'(wrst), 64'(hi));
      chk($sformatf("R7 flag j=%0d", j), 64'(d[0]), 64'(j >= 5));
      chk($sformatf("R10 scope j=%0d", j), 64'(wmode), hi ? 64'd2 : 64'd0);
      chk($sformatf("R10 mask j=%0d", j), wmask, hi ? 64'h8000_0001_1111_1111 : 64'h0);
    end
    rd(4'd3, d); chk("R11 enable cleared", 64'(d), 64'h42);
    rd(4'd0, d); chk("R7 counter at zero", 64'(d), 64'h0);

    // R8 clear flag
    wr(4'd5, 32'h0);
    rd(4'd4, d); chk("R8 flag cleared", 64'(d), 64'h0);

    // R10 mask written while stopped, R9 width 0 acts as 1
    wr(4'd7, 32'h2222_2222);
    wr(4'd8, 32'h0);
    wr(4'd6, 32'h0);
    wr(4'd1, 32'd2);
    wr(4'd2, 32'h4755);
    wr(4'd3, 32'h23);
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      hi = (j == 2);
      chk($sformatf("R9 width0 j=%0d", j), 64'(wrst), 64'(hi));
      chk($sformatf("R10 new mask j=%0d", j), wmask, hi ? 64'h2222_2222 : 64'h0);
      chk($sformatf("R10 scope1 j=%0d", j), 64'(wmode), hi ? 64'd1 : 64'd0);
    end

    // R12 expiry without reset-on-expiry
    wr(4'd5, 32'h1);
    wr(4'd1, 32'd3);
    wr(4'd3, 32'h1);
    wr(4'd2, 32'h4755);
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      rd(4'd4, d);
      chk($sformatf("R12 no pulse j=%0d", j), 64'(wrst), 64'h0);
      chk($sformatf("R7 flag nr j=%0d", j), 64'(d[0]), 64'(j >= 3));
    end
    rd(4'd3, d); chk("R12 enable kept", 64'(d), 64'h1);

    // R7 reload 0 expires on first tick
    wr(4'd3, 32'h0);
    wr(4'd5, 32'h0);
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h4755);
    wr(4'd3, 32'h1);
    @(negedge clk);
    rd(4'd4, d); chk("R7 reload zero", 64'(d), 64'h1);

    summary();
  end
endmodule